// File: doc/BRIEF.md
# Split Instruction/Data Cache Hit Counter

This block models the tag side of two separate set-associative caches, one for instruction fetches and one for data accesses. It stores no line data. It takes a stream of memory-access records, each with a two-bit kind and a physical address, and decides for every record whether the cache serving that kind would hit. For each of three access kinds it keeps two statistics: how many accesses arrived and how many of them hit. The statistics are read one at a time through a select/data port.

Records enter through a valid/ready handshake. A record is taken on every rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while reset is held and stays high from the first clock after reset. The block therefore never applies back-pressure and accepts one record per cycle. The upstream source may hold `in_valid` low for any number of cycles, and idle cycles change nothing. The hit/miss verdict appears on a plain result strobe one cycle after acceptance. It carries the kind of the record it belongs to and has no ready of its own.

Each cache replaces entries in first-in, first-out order. Every fill stamps the way with a per-set age that is one above the newest age in that set. A miss evicts the way with the oldest stamp. Hits never touch the stamps.

Top module: `trace_cache_stats`

## Requirements
- R1: With the default geometry (4 sets, 4 ways, 32-byte lines, 32-bit address), the set is `in_addr[6:5]` and the tag is `in_addr[31:7]`. Addresses in the same line hit each other. Lines that differ only in the set field never evict each other.
- R2: Kind code 0 is an instruction fetch and looks up only the instruction cache. Codes 1 (data read) and 2 (data write) share the data cache. A fill in one cache never makes the other cache hit.
- R3: After reset every way is empty, and an empty way never matches, including for tag value zero.
- R4: A miss fills an empty way if the set has one. Otherwise it replaces the way that was filled earliest. A hit does not change which way is replaced next.
- R5: The first-in, first-out order is kept across any number of fills to one set, including long runs where the 8-bit stamps must be rebased.
- R6: `rd_sel` selects a counter: 0 = fetch accesses, 1 = fetch hits, 2 = data-read accesses, 3 = data-read hits, 4 = data-write accesses, 5 = data-write hits; 6 and 7 read zero. A counter reflects an accepted record from the cycle after acceptance.
- R7: Counters are `CNT_W` bits wide (default 32) and hold at all-ones instead of wrapping.
- R8: An accepted record with kind code 3 sets `err_flag`, which stays set until reset. Such a record produces no result strobe and changes no counter and no tag.
- R9: `in_ready` is high in every cycle after the first clock following reset. Each accepted record of kind 0, 1 or 2 raises `res_valid` for exactly the next cycle, with `res_hit` and with `res_type` equal to its kind.
- R10: While reset is held, `in_ready`, `res_valid` and `err_flag` are low and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Access record offered |
| in_ready | output | 1 | Record can be taken this cycle |
| in_type | input | 2 | Access kind: 0 fetch, 1 data read, 2 data write, 3 illegal |
| in_addr | input | ADDR_W | Physical address of the access |
| rd_sel | input | 3 | Counter select for `rd_data` |
| res_valid | output | 1 | Result of the record accepted one cycle earlier |
| res_hit | output | 1 | 1 = that record hit |
| res_type | output | 2 | Kind of that record |
| err_flag | output | 1 | Sticky flag: an illegal kind was seen |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
A wrong tag, valid bit or stamp in either cache stays hidden until a later record lands in the same set. It then shows as a wrong `res_hit` one cycle after that record is accepted. It also shows as a hit counter that moves when it should not, or that fails to move. A stamp-ordering fault shows only once a set is full and evicts the wrong line. So the stimulus revisits full sets with more distinct lines than ways, and repeats the pattern for hundreds of fills so that stamp rebasing is reached. A fault in a counter shows on `rd_data` in the cycle after the record that should have moved it, and the bench rotates through every select value to see it.

// File: rtl/cache_stats_pkg.sv
package cache_stats_pkg;
  typedef enum logic [1:0] {
    ACC_IFETCH = 2'd0,
    ACC_DREAD  = 2'd1,
    ACC_DWRITE = 2'd2,
    ACC_BAD    = 2'd3
  } acc_kind_e;

  // counter slots, ordered as seen through the read select
  localparam int STAT_IF_ACC = 0;
  localparam int STAT_IF_HIT = 1;
  localparam int STAT_RD_ACC = 2;
  localparam int STAT_RD_HIT = 3;
  localparam int STAT_WR_ACC = 4;
  localparam int STAT_WR_HIT = 5;
  localparam int NUM_STATS   = 6;

  localparam int CACHE_INSTR = 0;
  localparam int CACHE_DATA  = 1;
  localparam int NUM_CACHES  = 2;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (inc && (value != {W{1'b1}})) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/victim_pick.sv
module victim_pick #(
  parameter int WAYS    = 4,
  parameter int STAMP_W = 8,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]         vld,
  input  logic [WAYS*STAMP_W-1:0] stamps,
  output logic [WAY_W-1:0]        victim,
  output logic [STAMP_W-1:0]      max_stamp,
  output logic [STAMP_W-1:0]      min_stamp,
  output logic                    any_vld
);
  logic             have_empty;
  logic             have_min;
  logic [WAY_W-1:0] empty_way;
  logic [WAY_W-1:0] oldest_way;
  logic [STAMP_W-1:0] cur;

  always_comb begin
    have_empty = 1'b0;
    have_min   = 1'b0;
    empty_way  = '0;
    oldest_way = '0;
    max_stamp  = '0;
    min_stamp  = '0;
    cur        = '0;
    for (int w = 0; w < WAYS; w++) begin
      cur = stamps[w*STAMP_W +: STAMP_W];
      if (!vld[w]) begin
        if (!have_empty) begin
          empty_way  = WAY_W'(w);
          have_empty = 1'b1;
        end
      end else begin
        if (!have_min || (cur < min_stamp)) begin
          min_stamp  = cur;
          oldest_way = WAY_W'(w);
          have_min   = 1'b1;
        end
        if (cur > max_stamp) begin
          max_stamp = cur;
        end
      end
    end
    victim  = have_empty ? empty_way : oldest_way;
    any_vld = |vld;
  end
endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int STAMP_W    = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int TAG_W     = LINE_W - IDX_W,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [LINE_W-1:0] line_addr,
  output logic              hit
);
  logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
  logic [STAMP_W-1:0] stamp_q [SETS][WAYS];
  logic [WAYS-1:0]    vld_q   [SETS];

  logic [IDX_W-1:0]        set_idx;
  logic [TAG_W-1:0]        tag_in;
  logic [WAYS-1:0]         match;
  logic [WAYS*STAMP_W-1:0] set_stamps;
  logic [WAY_W-1:0]        victim;
  logic [STAMP_W-1:0]      max_stamp;
  logic [STAMP_W-1:0]      min_stamp;
  logic                    any_vld;
  logic                    fill;
  logic                    rebase;
  logic [STAMP_W-1:0]      new_stamp;

  assign set_idx = line_addr[IDX_W-1:0];
  assign tag_in  = line_addr[LINE_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == tag_in);
    assign set_stamps[w*STAMP_W +: STAMP_W] = stamp_q[set_idx][w];
  end

  assign hit = |match;

  victim_pick #(
    .WAYS   (WAYS),
    .STAMP_W(STAMP_W)
  ) u_pick (
    .vld      (vld_q[set_idx]),
    .stamps   (set_stamps),
    .victim   (victim),
    .max_stamp(max_stamp),
    .min_stamp(min_stamp),
    .any_vld  (any_vld)
  );

  assign fill   = req && !hit;
  assign rebase = fill && any_vld && (max_stamp == {STAMP_W{1'b1}});

  always_comb begin
    if (!any_vld) begin
      new_stamp = '0;
    end else if (rebase) begin
      new_stamp = max_stamp - min_stamp + 1'b1;
    end else begin
      new_stamp = max_stamp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]   <= '0;
          stamp_q[s][w] <= '0;
        end
      end
    end else if (fill) begin
      if (rebase) begin
        for (int w = 0; w < WAYS; w++) begin
          if (vld_q[set_idx][w]) begin
            stamp_q[set_idx][w] <= stamp_q[set_idx][w] - min_stamp;
          end
        end
      end
      tag_q[set_idx][victim]   <= tag_in;
      stamp_q[set_idx][victim] <= new_stamp;
      vld_q[set_idx][victim]   <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_cache_stats.sv
module trace_cache_stats
  import cache_stats_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int STAMP_W    = 8,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [2:0]        rd_sel,
  output logic              res_valid,
  output logic              res_hit,
  output logic [1:0]        res_type,
  output logic              err_flag,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic                         accept;
  logic                         is_if, is_rd, is_wr, is_bad;
  logic [NUM_CACHES-1:0]        cache_req;
  logic [NUM_CACHES-1:0]        cache_hit;
  logic                         hit_now;
  logic [NUM_STATS-1:0]         stat_inc;
  logic [NUM_STATS*CNT_W-1:0]   cnt_flat;
  logic                         ready_q;
  logic                         unused_offset_bits;

  assign unused_offset_bits = ^in_addr[OFF_W-1:0];

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;
  assign is_if    = accept && (in_type == ACC_IFETCH);
  assign is_rd    = accept && (in_type == ACC_DREAD);
  assign is_wr    = accept && (in_type == ACC_DWRITE);
  assign is_bad   = accept && (in_type == ACC_BAD);

  assign cache_req[CACHE_INSTR] = is_if;
  assign cache_req[CACHE_DATA]  = is_rd || is_wr;

  for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
    tag_store #(
      .ADDR_W    (ADDR_W),
      .WAYS      (WAYS),
      .SETS      (SETS),
      .LINE_BYTES(LINE_BYTES),
      .STAMP_W   (STAMP_W)
    ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (cache_req[c]),
      .line_addr(in_addr[ADDR_W-1:OFF_W]),
      .hit      (cache_hit[c])
    );
  end

  assign hit_now = is_if ? cache_hit[CACHE_INSTR] : cache_hit[CACHE_DATA];

  always_comb begin
    stat_inc              = '0;
    stat_inc[STAT_IF_ACC] = is_if;
    stat_inc[STAT_IF_HIT] = is_if && cache_hit[CACHE_INSTR];
    stat_inc[STAT_RD_ACC] = is_rd;
    stat_inc[STAT_RD_HIT] = is_rd && cache_hit[CACHE_DATA];
    stat_inc[STAT_WR_ACC] = is_wr;
    stat_inc[STAT_WR_HIT] = is_wr && cache_hit[CACHE_DATA];
  end

  for (genvar k = 0; k < NUM_STATS; k++) begin : g_stat
    sat_counter #(
      .W(CNT_W)
    ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (stat_inc[k]),
      .value(cnt_flat[k*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_STATS; k++) begin
      if (int'(rd_sel) == k) begin
        rd_data = cnt_flat[k*CNT_W +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_type  <= 2'd0;
      err_flag  <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      res_valid <= accept && !is_bad;
      res_hit   <= hit_now;
      res_type  <= in_type;
      if (is_bad) begin
        err_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_cache_stats_chk.sv
module trace_cache_stats_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_type,
  input logic             res_valid,
  input logic [1:0]       res_type,
  input logic             err_flag,
  input logic [6*CNT_W-1:0] cnt_flat
);
  logic [CNT_W-1:0] if_acc, if_hit, rd_acc, rd_hit, wr_acc, wr_hit;
  assign if_acc = cnt_flat[0*CNT_W +: CNT_W];
  assign if_hit = cnt_flat[1*CNT_W +: CNT_W];
  assign rd_acc = cnt_flat[2*CNT_W +: CNT_W];
  assign rd_hit = cnt_flat[3*CNT_W +: CNT_W];
  assign wr_acc = cnt_flat[4*CNT_W +: CNT_W];
  assign wr_hit = cnt_flat[5*CNT_W +: CNT_W];

  assert_ready_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> in_ready);

  assert_result_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready && (in_type != 2'd3)));

  assert_accept_gives_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && (in_type != 2'd3)) |-> res_valid);

  assert_result_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_type == $past(in_type)));

  assert_no_result_for_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && (in_type == 2'd3)) |-> !res_valid);

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_error_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(in_valid && in_ready && (in_type == 2'd3)));

  assert_hits_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (if_hit <= if_acc) && (rd_hit <= rd_acc) && (wr_hit <= wr_acc));
endmodule

bind trace_cache_stats trace_cache_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_type  (in_type),
  .res_valid(res_valid),
  .res_type (res_type),
  .err_flag (err_flag),
  .cnt_flat (cnt_flat)
);

// File: tb/sim_trace_cache_stats.sv
`timescale 1ns/1ps
module sim_trace_cache_stats;
  localparam int CNT_W = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_type = 2'd0;
  logic [31:0] in_addr = 32'd0;
  logic [2:0]  rd_sel = 3'd0;
  logic        res_valid, res_hit, err_flag;
  logic [1:0]  res_type;
  logic [CNT_W-1:0] rd_data;

  always #4 clk = ~clk;

  trace_cache_stats #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_addr(in_addr), .rd_sel(rd_sel),
    .res_valid(res_valid), .res_hit(res_hit), .res_type(res_type),
    .err_flag(err_flag), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference state: per cache (0 instr, 1 data) and set, tags with fill order numbers
  longint ref_tag [2][4][4];
  longint ref_seq [2][4][4];
  bit     ref_vld [2][4][4];
  longint fill_no = 0;
  int     ref_cnt [6];
  bit     ref_err = 0;
  bit     exp_rv = 0;
  bit     exp_hit = 0;
  int     exp_type = 0;
  string  hit_tag = "R3";
  string  cnt_tag = "R6";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint mk(input int tag, input int set, input int off);
    return (longint'(tag) << 7) | (longint'(set) << 5) | longint'(off);
  endfunction

  function automatic bit ref_access(input int c, input longint addr);
    int set = int'((addr >> 5) & 3);
    longint tag = addr >> 7;
    int pick = -1;
    longint oldest = 0;
    for (int w = 0; w < 4; w++)
      if (ref_vld[c][set][w] && ref_tag[c][set][w] == tag) return 1;
    for (int w = 0; w < 4; w++)
      if (!ref_vld[c][set][w] && pick < 0) pick = w;
    if (pick < 0) begin
      for (int w = 0; w < 4; w++)
        if (pick < 0 || ref_seq[c][set][w] < oldest) begin
          pick = w; oldest = ref_seq[c][set][w];
        end
    end
    ref_vld[c][set][pick] = 1;
    ref_tag[c][set][pick] = tag;
    ref_seq[c][set][pick] = fill_no;
    fill_no++;
    return 0;
  endfunction

  function automatic void bump(input int k);
    if (ref_cnt[k] < MAXC) ref_cnt[k]++;
  endfunction

  task automatic cycle(input bit v, input int t, input longint a);
    int sel;
    bit h;
    @(negedge clk);
    check(res_valid == exp_rv, "R9", res_valid, exp_rv);
    if (exp_rv) begin
      check(res_hit == exp_hit, hit_tag, res_hit, exp_hit);
      check(int'(res_type) == exp_type, "R9", res_type, exp_type);
    end
    sel = int'(rd_sel);
    check(int'(rd_data) == ((sel < 6) ? ref_cnt[sel] : 0), cnt_tag, rd_data,
          (sel < 6) ? ref_cnt[sel] : 0);
    check(err_flag == ref_err, "R8", err_flag, ref_err);
    check(in_ready == 1'b1, "R9", in_ready, 1);
    in_valid = v;
    in_type  = 2'(t);
    in_addr  = 32'(a);
    rd_sel   = 3'((sel + 1) % 8);
    exp_rv   = 0;
    if (v) begin
      if (t == 3) ref_err = 1;
      else begin
        h = ref_access((t == 0) ? 0 : 1, a);
        bump(2 * t);
        if (h) bump(2 * t + 1);
        exp_rv = 1; exp_hit = h; exp_type = t;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++) ref_vld[c][s][w] = 0;
    for (int k = 0; k < 6; k++) ref_cnt[k] = 0;

    // R10: reset state
    repeat (3) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rd_sel = 3'(k);
      #1;
      check(rd_data == '0, "R10", rd_data, 0);
    end
    check(in_ready == 1'b0, "R10", in_ready, 0);
    check(res_valid == 1'b0, "R10", res_valid, 0);
    check(err_flag == 1'b0, "R10", err_flag, 0);
    rd_sel = 3'd0;
    rst_n = 1'b1;

    // R3: empty ways never match, tag 0 included
    hit_tag = "R3";
    cycle(1, 0, 0);
    cycle(1, 1, 0);
    cycle(1, 0, 4);

    // R1: line offset and set split
    hit_tag = "R1";
    cycle(1, 1, mk(9, 2, 0));
    cycle(1, 1, mk(9, 2, 31));
    for (int t = 1; t <= 5; t++) cycle(1, 1, mk(t, 3, 0));
    cycle(1, 1, mk(9, 2, 17));

    // R2: separate instruction and data arrays
    hit_tag = "R2";
    cycle(1, 0, mk(20, 1, 4));
    cycle(1, 1, mk(20, 1, 8));
    cycle(1, 2, mk(20, 1, 12));
    cycle(1, 0, mk(20, 1, 0));
    cycle(0, 0, 0);

    // R4: first-in first-out replacement, hits do not refresh
    hit_tag = "R4";
    for (int t = 30; t < 34; t++) cycle(1, 0, mk(t, 0, 0));
    cycle(1, 0, mk(30, 0, 0));
    cycle(1, 0, mk(34, 0, 0));
    cycle(1, 0, mk(31, 0, 0));
    cycle(1, 0, mk(30, 0, 0));
    cycle(1, 0, mk(33, 0, 0));

    // R8: illegal kind changes nothing
    hit_tag = "R8";
    cycle(1, 3, mk(50, 2, 0));
    cycle(1, 2, mk(50, 2, 0));
    cycle(1, 3, mk(51, 2, 0));
    cycle(0, 0, 0);

    // R5: long run of fills into one set forces stamp rebasing
    hit_tag = "R5";
    for (int i = 0; i < 600; i++) cycle(1, 1, mk(100 + (i % 5), 1, 0));
    for (int t = 100; t < 105; t++) cycle(1, 2, mk(t, 1, 0));
    for (int i = 0; i < 300; i++) cycle(1, 0, mk(200 + (i % 6), 2, 0));
    for (int t = 200; t < 206; t++) cycle(1, 0, mk(t, 2, 0));

    // R7: mixed traffic well past counter saturation
    hit_tag = "R4";
    cnt_tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 31));
      int t = (r == 0) ? 3 : (r % 3);
      bit v = ($urandom_range(0, 7) != 0);
      cycle(v, t, mk(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 31))));
    end
    for (int k = 0; k < 8; k++) cycle(0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule